// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that connects a two-wire bus to an 8-bit register file. It sees the bus through synchronised copies of the SDA and SCL lines. It pulls each line low through its own drive enable, so the pads work as open-drain. It finds start, repeated start and stop conditions. It answers only to the 7-bit address `0011 00X`, where X comes from a strap pin. That lets two of these targets share one bus.

A write transfer sends the address with the write bit, then a register-address byte, then any number of data bytes. Each data byte reaches the register file as a one-cycle write strobe. A read first sets the pointer with a short write phase. A repeated start and the address with the read bit follow, and the block returns bytes until the controller answers with NACK. The pointer steps after every data byte in both directions.

When the hold input is high, the block asks an external converter for a fresh result before each byte it sends. It pulls SCL low until the converter reports that it is no longer busy.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset neither SDA nor SCL is pulled low, and `reg_we_o`, `reg_re_o` and `conv_start_o` are low.
- R2: The address byte is the 7-bit address in bits 7..1 with the read flag (1 = read) in bit 0. Only the address `{6'b001100, addr_sel_i}` is acknowledged. Any other address gets no ACK, and the block neither drives the bus nor strobes a write until the next start.
- R3: A register-address byte with bit 7 clear is acknowledged and loads the pointer. With bit 7 set it is not acknowledged, and the rest of the transfer is ignored.
- R4: In a write, each data byte is acknowledged and produces exactly one single-cycle `reg_we_o` pulse. The pulse carries the current pointer on `reg_addr_o` and the byte on `reg_wdata_o`.
- R5: The pointer rises by one after every data byte, written or read, and wraps modulo 256.
- R6: Bytes move MSB first. The block changes its SDA drive only while SCL is low, and its ACK holds SDA low for the whole high phase of the ninth clock.
- R7: After a repeated start with the read flag set, the block returns the register at the pointer as each byte, and continues while the controller acknowledges. After a NACK it releases SDA and waits for the next start.
- R8: With `hold_en_i` high, every read byte is preceded by a one-cycle `conv_start_o` pulse. SCL is then held low until `conv_busy_i` falls, and the byte is loaded before SCL is released. With `hold_en_i` low, SCL is never pulled low and `conv_start_o` stays low.
- R9: A stop condition at any point releases both lines and returns to idle without a write. A repeated start restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| addr_sel_i | input | 1 | Strap that sets the address LSB |
| hold_en_i | input | 1 | Enables clock holding during conversions |
| scl_drive_low_o | output | 1 | Pull SCL low when high |
| sda_drive_low_o | output | 1 | Pull SDA low when high |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data to the register file |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle strobe when read data is captured |
| reg_rdata_i | input | 8 | Register file data at `reg_addr_o` |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| conv_busy_i | input | 1 | Converter busy; rises the cycle after a request |

## Verification
A wrong bit counter or shift register shows up within the same byte. Either the ACK appears on the wrong clock, or the read data no longer matches the register model. A wrong pointer update is seen at the next write strobe or the next read byte, because the scoreboard pairs each strobe with the address it expects. A state machine stuck in a receive or hold state shows up as a bus line left low after a stop, or as SCL held with the hold input low. Either appears within one bit time.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_REG,
        S_REG_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_CONV_ARM,
        S_CONV_WAIT,
        S_LOAD,
        S_RDATA,
        S_RDATA_ACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] ptr;
        logic              rw;
        logic              mack;
        logic              sda_low;
        logic              scl_low;
        logic              we;
        logic [BYTE_W-1:0] wdata;
        logic              conv;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] prev_d, prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] ch_d, ch_q;

        always_comb ch_d = {ch_q[STAGES-2:0], raw[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '1;
            else        ch_q <= ch_d;
        end

        assign line_s[g] = ch_q[STAGES-1];
    end

    always_comb prev_d = line_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_s     = line_s[0];
    assign sda_s     = line_s[1];
    assign scl_rise  =  line_s[0] & ~prev_q[0];
    assign scl_fall  = ~line_s[0] &  prev_q[0];
    assign start_det =  line_s[0] &  prev_q[0] &  prev_q[1] & ~line_s[1];
    assign stop_det  =  line_s[0] &  prev_q[0] & ~prev_q[1] &  line_s[1];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel_i,
    input  logic              hold_en_i,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    input  logic              conv_busy_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    output logic              conv_start_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    tgt_regs_t q, d;
    logic      go_read;
    logic      rx_state;

    assign rx_state = (q.st == S_ADDR) || (q.st == S_REG) || (q.st == S_WDATA);

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.conv  = 1'b0;
        go_read = 1'b0;
        if (stop_det) begin
            d.st      = S_IDLE;
            d.full    = 1'b0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else if (start_det) begin
            d.st      = S_ADDR;
            d.cnt     = '0;
            d.full    = 1'b0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else if (rx_state) begin
            if (scl_rise) begin
                d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_BIT) d.full = 1'b1;
            end else if (scl_fall && q.full) begin
                d.full = 1'b0;
                d.cnt  = '0;
                case (q.st)
                    S_ADDR: begin
                        if (q.sh[BYTE_W-1:1] == {ADDR_HI, addr_sel_i}) begin
                            d.sda_low = 1'b1;
                            d.rw      = q.sh[0];
                            d.st      = S_ADDR_ACK;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                    S_REG: begin
                        if (!q.sh[BYTE_W-1]) begin
                            d.ptr     = q.sh;
                            d.sda_low = 1'b1;
                            d.st      = S_REG_ACK;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                    default: begin
                        d.we      = 1'b1;
                        d.wdata   = q.sh;
                        d.sda_low = 1'b1;
                        d.st      = S_WDATA_ACK;
                    end
                endcase
            end
        end else begin
            case (q.st)
                S_ADDR_ACK: if (scl_fall) begin
                    d.sda_low = 1'b0;
                    if (q.rw) go_read = 1'b1;
                    else      d.st    = S_REG;
                end
                S_REG_ACK: if (scl_fall) begin
                    d.sda_low = 1'b0;
                    d.st      = S_WDATA;
                end
                S_WDATA_ACK: if (scl_fall) begin
                    d.sda_low = 1'b0;
                    d.ptr     = q.ptr + 1'b1;
                    d.st      = S_WDATA;
                end
                S_CONV_ARM:  d.st = S_CONV_WAIT;
                S_CONV_WAIT: if (!conv_busy_i) d.st = S_LOAD;
                S_LOAD: begin
                    d.tx      = reg_rdata_i;
                    d.sda_low = !reg_rdata_i[BYTE_W-1];
                    d.cnt     = '0;
                    d.st      = S_RDATA;
                end
                S_RDATA: begin
                    d.scl_low = 1'b0;
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) d.full = 1'b1;
                    end else if (scl_fall) begin
                        if (q.full) begin
                            d.full    = 1'b0;
                            d.sda_low = 1'b0;
                            d.st      = S_RDATA_ACK;
                        end else begin
                            d.tx      = {q.tx[BYTE_W-2:0], 1'b0};
                            d.sda_low = !q.tx[BYTE_W-2];
                        end
                    end
                end
                S_RDATA_ACK: begin
                    if (scl_rise) begin
                        d.mack = !sda_s;
                    end else if (scl_fall) begin
                        d.ptr = q.ptr + 1'b1;
                        if (q.mack) go_read = 1'b1;
                        else        d.st    = S_IDLE;
                    end
                end
                default: ;
            endcase
            if (go_read) begin
                if (hold_en_i) begin
                    d.conv    = 1'b1;
                    d.scl_low = 1'b1;
                    d.st      = S_CONV_ARM;
                end else begin
                    d.st = S_LOAD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_drive_low_o = q.scl_low;
    assign sda_drive_low_o = q.sda_low;
    assign reg_addr_o      = q.ptr;
    assign reg_wdata_o     = q.wdata;
    assign reg_we_o        = q.we;
    assign reg_re_o        = (q.st == S_LOAD);
    assign conv_start_o    = q.conv;

    // R6: own SDA drive moves only while the synchronised SCL is low
    p_sda_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !scl_s);

    // R8: clock holding starts only when the hold control is set
    p_hold_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low_o) |-> hold_en_i);

    // R8: a conversion request keeps SCL held in the following cycle
    p_conv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> scl_drive_low_o);

    // R4: write strobe is a single-cycle pulse
    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R9: a stop releases both lines and writes nothing
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_drive_low_o && !scl_drive_low_o && !reg_we_o));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b001100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic              hold_en_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              conv_start_o,
    input  logic              conv_busy_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_s           (scl_s),
        .sda_s           (sda_s),
        .scl_rise        (scl_rise),
        .scl_fall        (scl_fall),
        .start_det       (start_det),
        .stop_det        (stop_det),
        .addr_sel_i      (addr_sel_i),
        .hold_en_i       (hold_en_i),
        .reg_rdata_i     (reg_rdata_i),
        .conv_busy_i     (conv_busy_i),
        .scl_drive_low_o (scl_drive_low_o),
        .sda_drive_low_o (sda_drive_low_o),
        .reg_addr_o      (reg_addr_o),
        .reg_wdata_o     (reg_wdata_o),
        .reg_we_o        (reg_we_o),
        .reg_re_o        (reg_re_o),
        .conv_start_o    (conv_start_o)
    );

endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;

    localparam int Q_CYC    = 10;
    localparam int CONV_CYC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0, hold_en = 1'b0;
    logic scl_drive_low, sda_drive_low;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_we, reg_re, conv_start, conv_busy;
    logic scl_bus, sda_bus;

    logic [7:0] regs [256];
    logic [7:0] exp_regs [256];
    logic [15:0] wq [$];
    int busy_cnt = 0;
    int checks = 0, errors = 0;
    int conv_cnt = 0, stretch_cnt = 0, quiet_viol = 0, ack_glitch = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus   = m_scl & ~scl_drive_low;
    assign sda_bus   = m_sda & ~sda_drive_low;
    assign reg_rdata = regs[reg_addr];
    assign conv_busy = (busy_cnt != 0);

    i2c_reg_target uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_bus),
        .sda_i           (sda_bus),
        .addr_sel_i      (addr_sel),
        .hold_en_i       (hold_en),
        .scl_drive_low_o (scl_drive_low),
        .sda_drive_low_o (sda_drive_low),
        .reg_addr_o      (reg_addr),
        .reg_wdata_o     (reg_wdata),
        .reg_we_o        (reg_we),
        .reg_re_o        (reg_re),
        .reg_rdata_i     (reg_rdata),
        .conv_start_o    (conv_start),
        .conv_busy_i     (conv_busy)
    );

    // environment: register file and converter
    always @(posedge clk) begin
        if (reg_we) regs[reg_addr] <= reg_wdata;
        if (conv_start)        busy_cnt <= CONV_CYC;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: pops expected writes as strobes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R2/R3/R9 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = wq.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R4/R5 write strobe", {reg_addr, reg_wdata}, e);
                end
            end
            if (conv_start) conv_cnt++;
            if (scl_drive_low) stretch_cnt++;
            if (quiet && (sda_drive_low || scl_drive_low)) quiet_viol++;
        end
    end

    task automatic wait_q();
        repeat (Q_CYC) @(negedge clk);
    endtask

    task automatic wait_high();
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_high(); wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_high(); wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic m_bit(input logic b);
        m_sda = b; wait_q();
        m_scl = 1'b1; wait_high(); wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic a0, a1, a2;
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_high();
        a0 = !sda_bus; wait_q();
        a1 = !sda_bus; wait_q();
        a2 = !sda_bus;
        m_scl = 1'b0; wait_q();
        if (a0 != a1 || a0 != a2) ack_glitch++;
        ack = a0;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            m_scl = 1'b1; wait_high(); wait_q();
            d[i] = sda_bus; wait_q();
            m_scl = 1'b0;
        end
        wait_q();
        m_sda = !give_ack; wait_q();
        m_scl = 1'b1; wait_high(); wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic write_seq(input logic [6:0] dev, input logic [7:0] ra,
                             input int n, input logic [7:0] base);
        logic ack;
        logic [7:0] p, dat;
        m_start();
        m_wbyte({dev, 1'b0}, ack);
        chk(ack == 1'b1, "R2 address ACK on write", ack, 1);
        m_wbyte(ra, ack);
        chk(ack == 1'b1, "R3 register address ACK", ack, 1);
        p = ra;
        for (int i = 0; i < n; i++) begin
            dat = base + 8'(i * 8'h3B);
            wq.push_back({p, dat});
            exp_regs[p] = dat;
            m_wbyte(dat, ack);
            chk(ack == 1'b1, "R4 data byte ACK", ack, 1);
            p = p + 8'd1;
        end
        m_stop();
    endtask

    task automatic read_seq(input logic [6:0] dev, input logic [7:0] ra, input int n);
        logic ack;
        logic [7:0] d;
        logic [7:0] p;
        m_start();
        m_wbyte({dev, 1'b0}, ack);
        chk(ack == 1'b1, "R2 address ACK before read", ack, 1);
        m_wbyte(ra, ack);
        chk(ack == 1'b1, "R3 pointer ACK before read", ack, 1);
        m_start();
        m_wbyte({dev, 1'b1}, ack);
        chk(ack == 1'b1, "R9 address ACK after repeated start", ack, 1);
        p = ra;
        for (int i = 0; i < n; i++) begin
            m_rbyte(i != n - 1, d);
            chk(d == exp_regs[p], "R7/R6/R5 read data", d, exp_regs[p]);
            p = p + 8'd1;
        end
        m_stop();
        chk(sda_drive_low == 1'b0, "R7 SDA released after NACK", sda_drive_low, 0);
    endtask

    task automatic finish_run();
        chk(wq.size() == 0, "R4 all expected writes seen", wq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic ack;
        for (int i = 0; i < 256; i++) begin
            regs[i] = 8'h00;
            exp_regs[i] = 8'h00;
        end
        repeat (5) @(negedge clk);
        chk(sda_drive_low == 1'b0 && scl_drive_low == 1'b0, "R1 lines released in reset",
            {scl_drive_low, sda_drive_low}, 0);
        chk(reg_we == 1'b0 && reg_re == 1'b0 && conv_start == 1'b0, "R1 strobes low in reset",
            {reg_we, reg_re, conv_start}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4, R5: three-byte write burst
        write_seq(7'h18, 8'h10, 3, 8'hA5);

        // R2: foreign address is ignored entirely
        quiet = 1'b1;
        m_start();
        m_wbyte(8'h32, ack);
        chk(ack == 1'b0, "R2 foreign address NACK", ack, 0);
        m_wbyte(8'h10, ack);
        chk(ack == 1'b0, "R2 later byte ignored", ack, 0);
        m_wbyte(8'h55, ack);
        chk(ack == 1'b0, "R2 data ignored", ack, 0);
        m_stop();
        quiet = 1'b0;
        chk(quiet_viol == 0, "R2 no drive on foreign transfer", quiet_viol, 0);

        // R3: register address with bit 7 set
        m_start();
        m_wbyte(8'h30, ack);
        chk(ack == 1'b1, "R3 address ACK", ack, 1);
        quiet = 1'b1;
        m_wbyte(8'h90, ack);
        chk(ack == 1'b0, "R3 high pointer NACK", ack, 0);
        m_wbyte(8'h77, ack);
        chk(ack == 1'b0, "R3 following data ignored", ack, 0);
        m_stop();
        quiet = 1'b0;
        chk(quiet_viol == 0, "R3 no drive after rejected pointer", quiet_viol, 0);

        // R7, R8: read burst, hold disabled
        conv_cnt = 0;
        stretch_cnt = 0;
        read_seq(7'h18, 8'h10, 3);
        chk(conv_cnt == 0, "R8 no conversion with hold off", conv_cnt, 0);
        chk(stretch_cnt == 0, "R8 SCL never held with hold off", stretch_cnt, 0);

        // R5: pointer crosses 7F to 80
        write_seq(7'h18, 8'h7F, 2, 8'h5A);

        // R8: read with clock holding
        hold_en = 1'b1;
        conv_cnt = 0;
        stretch_cnt = 0;
        read_seq(7'h18, 8'h7E, 3);
        hold_en = 1'b0;
        chk(conv_cnt == 3, "R8 one conversion per read byte", conv_cnt, 3);
        chk(stretch_cnt >= 3 * CONV_CYC, "R8 SCL held through conversions", stretch_cnt, 3 * CONV_CYC);

        // R2: strap selects the other address
        addr_sel = 1'b1;
        repeat (5) @(negedge clk);
        write_seq(7'h19, 8'h20, 1, 8'h81);
        read_seq(7'h19, 8'h20, 1);
        quiet = 1'b1;
        m_start();
        m_wbyte(8'h30, ack);
        chk(ack == 1'b0, "R2 old address NACK with strap high", ack, 0);
        m_stop();
        quiet = 1'b0;
        chk(quiet_viol == 0, "R2 no drive with strap high", quiet_viol, 0);

        // R9: stop inside a data byte
        m_start();
        m_wbyte(8'h32, ack);
        chk(ack == 1'b1, "R9 address ACK", ack, 1);
        m_wbyte(8'h21, ack);
        chk(ack == 1'b1, "R9 pointer ACK", ack, 1);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
        m_stop();
        repeat (5) @(negedge clk);
        chk(sda_drive_low == 1'b0 && scl_drive_low == 1'b0, "R9 lines released after stop",
            {scl_drive_low, sda_drive_low}, 0);
        read_seq(7'h19, 8'h21, 1);

        chk(ack_glitch == 0, "R6 ACK steady for whole high phase", ack_glitch, 0);

        done = 1'b1;
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule